// File: doc/BRIEF.md
# Acquisition trigger and interrupt control

This block holds one 8-bit control word that a host reads and writes over a small register port, together with the logic that the word steers. It picks the clock enable for each of two counter/timers from a set of reference-rate enables or an external clock pin. It routes one of three sources to the converter start strobe: a software convert strobe, the output of counter 0, or an external trigger pin. It also drives a DMA enable output.

Three request inputs (analog input, digital I/O, timer) each set their own pending bit on a rising edge, but only while that source is enabled. All pending bits are combined onto one shared interrupt line. Software reads the pending bits at the second register address to see which source asked for service. It then writes ones to that address to clear them. While analog interrupts are enabled, the software strobe cannot start a conversion. The start then comes from counter 0 or from the external pin, according to a control bit. The counters and the converter themselves lie outside the block.

Top module: `acq_irq_ctrl`

## Requirements
- R1: After synchronous reset every control bit and every pending bit is 0. So `irq` and `dma_en` are 0, and reading address 0 returns 0.
- R2: A write with `reg_addr`=0 loads `reg_wdata` into the control word at the clock edge. Reading address 0 returns it. Bit positions, 7 down to 0: counter-1 external source, counter-1 slow rate, counter-0 slow rate, external trigger select, DMA enable, timer interrupt enable, digital I/O interrupt enable, analog interrupt enable.
- R3: `ctr0_ce` equals `ce_10m` when bit 5 is 0, and `ce_1m` when bit 5 is 1.
- R4: With bit 7 at 0, `ctr1_ce` equals `ce_10m` (bit 6 = 0) or `ce_100k` (bit 6 = 1). With bit 7 at 1, it is a one-cycle pulse per rising edge of `ext_clk1`. The pulse is high in the cycle after the second clock edge that samples the pin high.
- R5: With bit 0 at 0, `adc_start` follows `sw_convert` in the same cycle. With bit 0 at 1, `sw_convert` has no effect on `adc_start`.
- R6: With bit 0 at 1 and bit 4 at 0, `adc_start` is high for exactly the one cycle in which `ctr0_out` is first high after being low at the previous edge.
- R7: With bits 0 and 4 at 1, `adc_start` is a one-cycle pulse per rising edge of `ext_trig`, with the same two-edge delay as in R4.
- R8: A pending bit is set at the edge where its request input is high after being low at the previous edge, and only if its enable bit is 1. Requests arriving while the source is disabled leave the bit at 0. The request inputs are `req_ain`, `req_dio` and `req_tmr`, with enables in bits 0, 1 and 2.
- R9: `irq` is high whenever any pending bit is 1. A pending bit stays set until a write to address 1 with a 1 in its position.
- R10: If a clear write and an enabled rising request reach the same bit at the same edge, the bit is 1 afterwards.
- R11: `dma_en` equals control bit 3.
- R12: Reading address 1 returns the pending bits in positions 0 (analog), 1 (digital I/O) and 2 (timer), with 0 in bits 7 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 1 | 0 = control word, 1 = pending bits (read) / clear (write ones) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| ce_10m | input | 1 | 10 MHz reference clock enable |
| ce_1m | input | 1 | 1 MHz reference clock enable |
| ce_100k | input | 1 | 100 kHz reference clock enable |
| ext_clk1 | input | 1 | External clock pin for counter 1 |
| ext_trig | input | 1 | External conversion trigger pin |
| ctr0_out | input | 1 | Output of counter 0 |
| req_ain | input | 1 | Analog input service request |
| req_dio | input | 1 | Digital I/O service request |
| req_tmr | input | 1 | Timer service request |
| sw_convert | input | 1 | Software convert strobe |
| ctr0_ce | output | 1 | Clock enable for counter 0 |
| ctr1_ce | output | 1 | Clock enable for counter 1 |
| adc_start | output | 1 | Conversion start strobe |
| irq | output | 1 | Shared interrupt line |
| dma_en | output | 1 | DMA enable |

## Verification
Directed sequences come first. They try each trigger mode with `sw_convert`, `ctr0_out` and `ext_trig` active one at a time, which separates a trigger mux that ignores the enable bit from one that ignores the select bit. Requests are then pulsed with their enable off and on, and a clear is issued in the same cycle as a new request. These cases separate enable gating and request-over-clear priority from a plain level latch. A long stretch of pseudo-random rate enables, pin toggles, requests and register writes follows, with every output compared against the bench model on every cycle. This stretch exposes wrong bit positions, swapped rate selections and off-by-one synchronizer delays.

// File: rtl/acq_ctl_pkg.sv
package acq_ctl_pkg;

    localparam int REG_W   = 8;
    localparam int NUM_SRC = 3;

    // Field order matches the register bit layout, bit 7 first.
    typedef struct packed {
        logic c1_ext;    // counter 1 from external pin
        logic c1_slow;   // counter 1 internal slow rate
        logic c0_slow;   // counter 0 slow rate
        logic trig_ext;  // conversion trigger from external pin
        logic dma_on;    // DMA enable
        logic tmr_ie;    // timer interrupt enable
        logic dio_ie;    // digital I/O interrupt enable
        logic ain_ie;    // analog interrupt enable
    } ctl_t;

    typedef enum logic {
        ADDR_CTL  = 1'b0,
        ADDR_STAT = 1'b1
    } addr_e;

    // Enable vector in pending-bit order: analog, digital I/O, timer.
    function automatic logic [NUM_SRC-1:0] irq_enables(input ctl_t c);
        return {c.tmr_ie, c.dio_ie, c.ain_ie};
    endfunction

endpackage

// File: rtl/acq_sync_edge.sv
module acq_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic pulse
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain[0] <= pin;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
            last <= chain[STAGES-1];
        end
    end

    assign pulse = chain[STAGES-1] & ~last;
endmodule

// File: rtl/acq_ctl_reg.sv
module acq_ctl_reg
    import acq_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output ctl_t             ctl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (reg_wr && addr_e'(reg_addr) == ADDR_CTL) begin
            ctl <= ctl_t'(reg_wdata);
        end
    end
endmodule

// File: rtl/acq_irq_bank.sv
module acq_irq_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic [N-1:0] en,
    input  logic [N-1:0] clr,
    output logic [N-1:0] status,
    output logic [N-1:0] rise
);
    for (genvar g = 0; g < N; g++) begin : g_src
        logic prev;

        assign rise[g] = req[g] & ~prev;

        always_ff @(posedge clk) begin
            if (rst) begin
                prev      <= 1'b0;
                status[g] <= 1'b0;
            end else begin
                prev <= req[g];
                // A fresh enabled request overrides a clear in the same cycle.
                if (rise[g] && en[g]) begin
                    status[g] <= 1'b1;
                end else if (clr[g]) begin
                    status[g] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/acq_irq_ctrl.sv
module acq_irq_ctrl
    import acq_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             ce_10m,
    input  logic             ce_1m,
    input  logic             ce_100k,
    input  logic             ext_clk1,
    input  logic             ext_trig,
    input  logic             ctr0_out,
    input  logic             req_ain,
    input  logic             req_dio,
    input  logic             req_tmr,
    input  logic             sw_convert,
    output logic             ctr0_ce,
    output logic             ctr1_ce,
    output logic             adc_start,
    output logic             irq,
    output logic             dma_en
);
    localparam int PAD_W = REG_W - NUM_SRC;

    ctl_t               ctl;
    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] req_rise;
    logic [NUM_SRC-1:0] clr_mask;
    logic               ext1_pulse;
    logic               trig_pulse;
    logic               ctr0_prev;
    logic               ctr0_rise;

    acq_ctl_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .ctl       (ctl)
    );

    acq_sync_edge #(.STAGES(SYNC_STAGES)) u_ext1 (
        .clk   (clk),
        .rst   (rst),
        .pin   (ext_clk1),
        .pulse (ext1_pulse)
    );

    acq_sync_edge #(.STAGES(SYNC_STAGES)) u_trig (
        .clk   (clk),
        .rst   (rst),
        .pin   (ext_trig),
        .pulse (trig_pulse)
    );

    assign clr_mask = (reg_wr && addr_e'(reg_addr) == ADDR_STAT)
                    ? reg_wdata[NUM_SRC-1:0] : '0;

    acq_irq_bank #(.N(NUM_SRC)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .req    ({req_tmr, req_dio, req_ain}),
        .en     (irq_enables(ctl)),
        .clr    (clr_mask),
        .status (status),
        .rise   (req_rise)
    );

    always_ff @(posedge clk) begin
        if (rst) ctr0_prev <= 1'b0;
        else     ctr0_prev <= ctr0_out;
    end
    assign ctr0_rise = ctr0_out & ~ctr0_prev;

    // Rate selection for the two counters.
    always_comb begin
        ctr0_ce = ctl.c0_slow ? ce_1m : ce_10m;
        if (ctl.c1_ext)       ctr1_ce = ext1_pulse;
        else if (ctl.c1_slow) ctr1_ce = ce_100k;
        else                  ctr1_ce = ce_10m;
    end

    // Conversion start: software strobe only while analog interrupts are off.
    always_comb begin
        if (!ctl.ain_ie)       adc_start = sw_convert;
        else if (ctl.trig_ext) adc_start = trig_pulse;
        else                   adc_start = ctr0_rise;
    end

    assign reg_rdata = (addr_e'(reg_addr) == ADDR_STAT)
                     ? {{PAD_W{1'b0}}, status} : REG_W'(ctl);
    assign irq    = |status;
    assign dma_en = ctl.dma_on;
endmodule

// File: rtl/acq_irq_ctrl_chk.sv
module acq_irq_ctrl_chk
    import acq_ctl_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               reg_wr,
    input logic               reg_addr,
    input logic [REG_W-1:0]   reg_wdata,
    input ctl_t               ctl,
    input logic [NUM_SRC-1:0] status,
    input logic [NUM_SRC-1:0] req_rise,
    input logic               irq,
    input logic               adc_start,
    input logic               ctr0_out,
    input logic               ce_10m,
    input logic               ce_1m,
    input logic               ctr0_ce
);
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctl == '0 && status == '0));

    p_ctr0_rate_r3: assert property (@(posedge clk) disable iff (rst)
        ctr0_ce |-> (ce_10m || ce_1m));

    p_sw_blocked_r5: assert property (@(posedge clk) disable iff (rst)
        (ctl.ain_ie && !ctl.trig_ext && !ctr0_out) |-> !adc_start);

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_en
        p_set_needs_enable_r8: assert property (@(posedge clk) disable iff (rst)
            $rose(status[k]) |-> $past(irq_enables(ctl)) [k]);
    end

    p_irq_held_r9: assert property (@(posedge clk) disable iff (rst)
        (irq && !(reg_wr && reg_addr && (|reg_wdata[NUM_SRC-1:0]))) |=> irq);

    p_req_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr && reg_wdata[0] && req_rise[0] && ctl.ain_ie)
        |=> status[0]);
endmodule

bind acq_irq_ctrl acq_irq_ctrl_chk u_chk (.*);

// File: tb/acq_irq_ctrl_test.sv
`timescale 1ns/1ps
module acq_irq_ctrl_test;
    localparam int SYNC = 2;

    logic       clk = 1'b0, rst = 1'b1;
    logic       reg_wr = 0, reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic ce_10m = 0, ce_1m = 0, ce_100k = 0, ext_clk1 = 0, ext_trig = 0, ctr0_out = 0;
    logic req_ain = 0, req_dio = 0, req_tmr = 0, sw_convert = 0;
    logic ctr0_ce, ctr1_ce, adc_start, irq, dma_en;

    always #2.5 clk = ~clk;

    acq_irq_ctrl #(.SYNC_STAGES(SYNC)) uut (.*);

    int n_chk = 0, n_fail = 0;

    // Reference model state
    logic [7:0] m_ctl = 0;
    logic [2:0] m_st = 0, m_rq_prev = 0;
    logic       m_c0_prev = 0;
    logic       m_e1 [0:SYNC];
    logic       m_tr [0:SYNC];

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic e1p, trp, exp_adc, exp_c1;
        string adc_tag;
        if (rst) return;
        e1p = m_e1[SYNC-1] & ~m_e1[SYNC];
        trp = m_tr[SYNC-1] & ~m_tr[SYNC];
        exp_c1 = m_ctl[7] ? e1p : (m_ctl[6] ? ce_100k : ce_10m);
        if (!m_ctl[0]) begin exp_adc = sw_convert; adc_tag = "R5"; end
        else if (m_ctl[4]) begin exp_adc = trp; adc_tag = "R7"; end
        else begin exp_adc = ctr0_out & ~m_c0_prev; adc_tag = "R6"; end
        chk("R3 ctr0_ce", ctr0_ce, m_ctl[5] ? ce_1m : ce_10m);
        chk("R4 ctr1_ce", ctr1_ce, exp_c1);
        chk({adc_tag, " adc_start"}, adc_start, exp_adc);
        chk("R9 irq", irq, |m_st);
        chk("R11 dma_en", dma_en, m_ctl[3]);
        if (reg_addr) chk("R12 status read", reg_rdata, {5'b0, m_st});
        else          chk("R2 control read", reg_rdata, m_ctl);
    endtask

    task automatic update_model();
        logic [2:0] req, set, clr;
        if (rst) begin
            m_ctl = 0; m_st = 0; m_rq_prev = 0; m_c0_prev = 0;
            for (int i = 0; i <= SYNC; i++) begin m_e1[i] = 0; m_tr[i] = 0; end
            return;
        end
        req = {req_tmr, req_dio, req_ain};
        set = req & ~m_rq_prev & m_ctl[2:0];
        clr = (reg_wr && reg_addr) ? reg_wdata[2:0] : 3'b0;
        m_st = (m_st & ~clr) | set;
        if (reg_wr && !reg_addr) m_ctl = reg_wdata;
        m_rq_prev = req;
        m_c0_prev = ctr0_out;
        for (int i = SYNC; i > 0; i--) begin m_e1[i] = m_e1[i-1]; m_tr[i] = m_tr[i-1]; end
        m_e1[0] = ext_clk1;
        m_tr[0] = ext_trig;
    endtask

    task automatic tick();
        #1;
        compare_all();
        update_model();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog (all requirements): got hang expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i <= SYNC; i++) begin m_e1[i] = 0; m_tr[i] = 0; end
        repeat (3) tick();
        rst = 0;
        #1;
        chk("R1 control after reset", reg_rdata, 8'h00);
        chk("R1 irq after reset", irq, 0);
        chk("R1 dma_en after reset", dma_en, 0);
        tick();

        // R2 / R11 layout
        wr(0, 8'h5A); reg_addr = 0; #1;
        chk("R2 readback", reg_rdata, 8'h5A);
        chk("R11 dma bit", dma_en, 1);
        tick();

        // R3 counter 0 rate
        wr(0, 8'h20); ce_1m = 1; ce_10m = 0; #1;
        chk("R3 slow rate", ctr0_ce, 1);
        tick(); ce_1m = 0;

        // R5 software strobe passes, then is blocked
        wr(0, 8'h00); sw_convert = 1; #1;
        chk("R5 software start", adc_start, 1);
        tick();
        wr(0, 8'h01); sw_convert = 1; ctr0_out = 0; #1;
        chk("R5 software blocked", adc_start, 0);
        tick(); sw_convert = 0;

        // R6 counter 0 edge
        ctr0_out = 1; #1;
        chk("R6 edge pulse", adc_start, 1);
        tick(); #1;
        chk("R6 single cycle", adc_start, 0);
        tick(); ctr0_out = 0;

        // R7 external trigger timing
        wr(0, 8'h11); ext_trig = 1;
        tick(); chk("R7 after one edge", adc_start, 0);
        tick(); chk("R7 after two edges", adc_start, 1);
        tick(); chk("R7 pulse ends", adc_start, 0);
        ext_trig = 0;

        // R4 external clock for counter 1
        wr(0, 8'h80); ce_10m = 1; ext_clk1 = 1;
        tick(); chk("R4 ext after one edge", ctr1_ce, 0);
        tick(); chk("R4 ext after two edges", ctr1_ce, 1);
        tick(); ext_clk1 = 0; ce_10m = 0;

        // R8 disabled request ignored, then enabled request
        wr(0, 8'h00); wr(1, 8'h07);
        req_dio = 1; tick(); req_dio = 0; tick();
        reg_addr = 1; #1;
        chk("R8 disabled request ignored", reg_rdata, 8'h00);
        tick();
        wr(0, 8'h02);
        req_dio = 1; tick(); req_dio = 0;
        reg_addr = 1; #1;
        chk("R8 enabled request sets", reg_rdata, 8'h02);
        chk("R9 irq raised", irq, 1);
        tick(); tick(); tick();
        chk("R9 irq held", irq, 1);
        wr(1, 8'h02);
        chk("R9 irq cleared", irq, 0);

        // R10 clear and request in same cycle
        wr(0, 8'h01);
        req_ain = 1; tick(); req_ain = 0; tick();
        reg_wr = 1; reg_addr = 1; reg_wdata = 8'h01; req_ain = 1;
        tick();
        reg_wr = 0; req_ain = 0;
        chk("R10 request wins", reg_rdata, 8'h01);
        tick();

        // Pseudo-random phase compared against the model every cycle
        for (int n = 0; n < 3000; n++) begin
            ce_10m     = ($urandom_range(0, 3) == 0);
            ce_1m      = ($urandom_range(0, 9) == 0);
            ce_100k    = ($urandom_range(0, 15) == 0);
            ext_clk1   = $urandom_range(0, 1);
            ext_trig   = ($urandom_range(0, 3) == 0);
            ctr0_out   = $urandom_range(0, 1);
            req_ain    = ($urandom_range(0, 5) == 0);
            req_dio    = ($urandom_range(0, 5) == 0);
            req_tmr    = ($urandom_range(0, 5) == 0);
            sw_convert = $urandom_range(0, 1);
            reg_addr   = $urandom_range(0, 1);
            reg_wr     = ($urandom_range(0, 7) == 0);
            reg_wdata  = 8'($urandom_range(0, 255));
            tick();
        end
        reg_wr = 0;
        summary();
        $finish;
    end
endmodule